// File: doc/BRIEF.md
# Five-Bit Opcode ALU with Held Result Register

This block is a small arithmetic/logic unit that works on two 5-bit operands under a 3-bit operation code. The result goes into a clocked register that also holds a carry bit and a zero flag. The opcode is split into two fields. The low two bits pick an operation group, and the high bit modifies the choice within that group.

Two operations may leave the stored result as it is. The compare operation writes zero only when the operands match. The carry-forcing operation touches nothing but the carry. Because of this, the next-value logic always starts from the current register contents, so every output has a value on every path. A caller presents operands and an opcode in one cycle and reads the result after the next rising clock edge.

Top module: `alu5_unit`

## Requirements
- R1: A synchronous active-high reset clears the result, the carry and the zero flag at the next rising edge.
- R2: Opcode 3'b000 loads the bitwise AND of a and b and clears the carry.
- R3: Opcode 3'b110 loads (a - b) modulo 32, formed as a + ~b + 1 over five ripple stages. The carry is the final stage carry, which is 1 exactly when a >= b as unsigned numbers.
- R4: Opcode 3'b011 with a equal to b loads all zeros and clears the carry.
- R5: Opcode 3'b011 with a different from b keeps the stored result unchanged and clears the carry.
- R6: Opcode 3'b111 keeps the stored result unchanged and sets the carry to 1.
- R7: Opcodes 3'b001, 3'b010, 3'b100 and 3'b101 load all zeros and clear the carry.
- R8: After every edge, the zero flag is 1 exactly when the stored result is all zeros, including after a hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| a_i | input | 5 | First operand |
| b_i | input | 5 | Second operand, the subtrahend for subtract |
| op_i | input | 3 | Operation code; bit 2 modifies, bits 1..0 select the group |
| res_o | output | 5 | Registered result |
| carry_o | output | 1 | Registered carry-out |
| zero_o | output | 1 | Registered flag, set when the result is zero |

## Verification
The bench drives every opcode across every pair of operands. Each pair runs through all eight codes in turn, so a compare or carry-force always follows a result that the earlier codes left behind. A design that wrote some new value on a mismatched compare, or on a carry-force, would be caught as soon as the held value was nonzero. A subtract whose carry was inverted into a borrow, or whose wrap below zero was wrong, shows up at the equal and just-below-equal operand pairs. A zero flag computed from the incoming operation rather than from the value actually stored would fail after any hold of a nonzero result. A reset applied while the register holds a nonzero value checks that all three outputs clear.

// File: rtl/alu5_pkg.sv
package alu5_pkg;

    localparam int DEF_WIDTH = 5;
    localparam int OPC_W     = 3;

    // operation chosen after splitting the opcode into group and modifier
    typedef enum logic [2:0] {
        K_AND   = 3'd0,
        K_SUB   = 3'd1,
        K_SETEQ = 3'd2,
        K_SETC  = 3'd3,
        K_CLEAR = 3'd4
    } alu_kind_e;

    typedef struct packed {
        logic [1:0] group;
        logic       modifier;
    } opc_fields_t;

    typedef struct packed {
        alu_kind_e kind;
        logic      uses_sub;
    } alu_ctrl_t;

    function automatic opc_fields_t split_opc(input logic [OPC_W-1:0] op);
        opc_fields_t f;
        f.group    = op[1:0];
        f.modifier = op[2];
        return f;
    endfunction

    function automatic alu_kind_e kind_of(input opc_fields_t f);
        alu_kind_e k;
        case (f.group)
            2'b00:   k = f.modifier ? K_CLEAR : K_AND;
            2'b10:   k = f.modifier ? K_SUB   : K_CLEAR;
            2'b11:   k = f.modifier ? K_SETC  : K_SETEQ;
            default: k = K_CLEAR;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/alu5_opdecode.sv
module alu5_opdecode
    import alu5_pkg::*;
(
    input  logic [OPC_W-1:0] op_i,
    output alu_ctrl_t        ctrl_o
);
    opc_fields_t fields;

    always_comb begin
        fields          = split_opc(op_i);
        ctrl_o.kind     = kind_of(fields);
        ctrl_o.uses_sub = (ctrl_o.kind == K_SUB);
    end
endmodule

// File: rtl/alu5_ripple_sub.sv
module alu5_ripple_sub #(
    parameter int WIDTH = 5
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] diff_o,
    output logic             cout_o
);
    logic [WIDTH:0]   chain;
    logic [WIDTH-1:0] b_inv;

    assign b_inv    = ~b_i;
    assign chain[0] = 1'b1;

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        assign diff_o[i]  = a_i[i] ^ b_inv[i] ^ chain[i];
        assign chain[i+1] = (a_i[i] & b_inv[i]) | (b_inv[i] & chain[i]) | (chain[i] & a_i[i]);
    end

    assign cout_o = chain[WIDTH];
endmodule

// File: rtl/alu5_datapath.sv
module alu5_datapath
    import alu5_pkg::*;
#(
    parameter int WIDTH = 5
) (
    input  alu_ctrl_t        ctrl_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [WIDTH-1:0] held_i,
    output logic [WIDTH-1:0] res_nxt_o,
    output logic             carry_nxt_o
);
    localparam logic [WIDTH-1:0] ZERO = '0;

    logic [WIDTH-1:0] diff;
    logic             sub_cout;

    alu5_ripple_sub #(.WIDTH(WIDTH)) i_sub (
        .a_i    (a_i),
        .b_i    (b_i),
        .diff_o (diff),
        .cout_o (sub_cout)
    );

    always_comb begin
        // defaults: keep the stored result, carry low
        res_nxt_o   = held_i;
        carry_nxt_o = 1'b0;
        case (ctrl_i.kind)
            K_AND:   res_nxt_o = a_i & b_i;
            K_SUB: begin
                res_nxt_o   = diff;
                carry_nxt_o = sub_cout & ctrl_i.uses_sub;
            end
            K_SETEQ: if (a_i == b_i) res_nxt_o = ZERO;
            K_SETC:  carry_nxt_o = 1'b1;
            default: res_nxt_o = ZERO;
        endcase
    end
endmodule

// File: rtl/alu5_unit.sv
module alu5_unit
    import alu5_pkg::*;
#(
    parameter int WIDTH = DEF_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [OPC_W-1:0] op_i,
    output logic [WIDTH-1:0] res_o,
    output logic             carry_o,
    output logic             zero_o
);
    alu_ctrl_t        ctrl;
    logic [WIDTH-1:0] res_nxt;
    logic             carry_nxt;
    logic [WIDTH-1:0] res_q;
    logic             carry_q;
    logic             zero_q;

    alu5_opdecode i_dec (
        .op_i   (op_i),
        .ctrl_o (ctrl)
    );

    alu5_datapath #(.WIDTH(WIDTH)) i_dp (
        .ctrl_i      (ctrl),
        .a_i         (a_i),
        .b_i         (b_i),
        .held_i      (res_q),
        .res_nxt_o   (res_nxt),
        .carry_nxt_o (carry_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q   <= '0;
            carry_q <= 1'b0;
            zero_q  <= 1'b0;
        end else begin
            res_q   <= res_nxt;
            carry_q <= carry_nxt;
            zero_q  <= (res_nxt == '0);
        end
    end

    assign res_o   = res_q;
    assign carry_o = carry_q;
    assign zero_o  = zero_q;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (res_q == '0 && !carry_q && !zero_q));

    // R2
    and_load_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'b000) |=> (res_q == $past(a_i & b_i) && !carry_q));

    // R5
    eq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'b011 && a_i != b_i) |=> ($stable(res_q) && !carry_q));

    // R6
    setc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'b111) |=> ($stable(res_q) && carry_q));

    // R7
    other_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'b001 || op_i == 3'b010 || op_i == 3'b100 || op_i == 3'b101)
        |=> (res_q == '0 && !carry_q));

    // R8
    zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> (zero_q == (res_q == '0)));
endmodule

// File: tb/test_alu5_unit.sv
`timescale 1ns/1ps
module test_alu5_unit;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] a   = '0;
    logic [4:0] b   = '0;
    logic [2:0] op  = '0;
    logic [4:0] res;
    logic       carry;
    logic       zero;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    int exp_res   = 0;
    int exp_carry = 0;

    always #2.5 clk = ~clk;

    alu5_unit i_alu5_unit (
        .clk     (clk),
        .rst     (rst),
        .a_i     (a),
        .b_i     (b),
        .op_i    (op),
        .res_o   (res),
        .carry_o (carry),
        .zero_o  (zero)
    );

    task automatic chk(input string req, input int act, input int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d (a=%0d b=%0d op=%0d)",
                     req, act, expv, a, b, op);
        end
    endtask

    task automatic step(input int av, input int bv, input int ov);
        string req;
        @(negedge clk);
        a  = av[4:0];
        b  = bv[4:0];
        op = ov[2:0];
        exp_carry = 0;
        case (ov)
            0: begin req = "R2"; exp_res = av & bv; end
            6: begin
                req = "R3";
                exp_res   = (av + 32 - bv) % 32;
                exp_carry = (av >= bv) ? 1 : 0;
            end
            3: begin
                if (av == bv) begin req = "R4"; exp_res = 0; end
                else req = "R5";
            end
            7: begin req = "R6"; exp_carry = 1; end
            default: begin req = "R7"; exp_res = 0; end
        endcase
        @(posedge clk);
        #1;
        chk({req, " result"}, int'(res), exp_res);
        chk({req, " carry"}, int'(carry), exp_carry);
        chk("R8 zero flag", int'(zero), (exp_res == 0) ? 1 : 0);
    endtask

    initial begin
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 result", int'(res), 0);
        chk("R1 carry", int'(carry), 0);
        chk("R1 zero", int'(zero), 0);
        @(negedge clk);
        rst = 1'b0;
        exp_res = 0;

        for (int ia = 0; ia < 32; ia++)
            for (int ib = 0; ib < 32; ib++)
                for (int iop = 0; iop < 8; iop++)
                    step(ia, ib, iop);

        // reset while holding a nonzero value with carry set
        step(19, 7, 0);
        step(0, 1, 7);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        chk("R1 result after run", int'(res), 0);
        chk("R1 carry after run", int'(carry), 0);
        chk("R1 zero after run", int'(zero), 0);
        @(negedge clk);
        rst = 1'b0;
        exp_res = 0;
        step(9, 9, 6);

        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule